// File: doc/BRIEF.md
# Link Control-Store Boot Loader

This block brings up a processor's microcode from a point-to-point inter-processor link, which is the preferred boot source. A stream of 16-bit link words comes in. Each group of three consecutive words is packed into one 48-bit microinstruction. The microinstructions are written into the control store at consecutive addresses, starting at zero. Once 256 microinstructions have been written, the block raises a completion flag. Nothing is summed or verified: every word lands in the store exactly as received.

The same block also has two link test modes. In the echo mode, every received word goes back out on the transmit side unchanged. In the pattern mode, a small computed test-pattern ROM is sent repeatedly so that the far end can check the link. Words enter through a receive holding register. Outgoing words leave from a transmit holding register. Both link directions use a per-word valid/ready handshake. The control-store write port is stalled by a busy input.

Top module: `link_cs_loader`

## Requirements
- R1: While and right after reset, `rx_ready` is 1 and `tx_valid`, `cs_we` and `boot_done` are 0.
- R2: In boot mode (`mode_sel` = 0), three consecutive accepted words w0, w1, w2 form one control-store word {w2, w1, w0}, so the first word is bits 15:0 and the third word is bits 47:32.
- R3: The write address is 0 for the first microinstruction and increases by one after each accepted write.
- R4: A write is accepted only on a cycle where `cs_we` is 1 and `cs_busy` is 0. While `cs_busy` is 1, `cs_we`, `cs_addr` and `cs_wdata` hold their values, and the loader takes no further instruction-completing word.
- R5: `boot_done` becomes 1 in the cycle after the write to address 255 is accepted, and it stays 1 until reset. After that, `cs_we` stays 0, and words arriving in boot mode are still accepted and then discarded.
- R6: No checksum is computed or checked. Words of all zeros and all ones are stored exactly as received.
- R7: In echo mode (`mode_sel` = 1), every received word is sent on `tx_data` unchanged and in arrival order.
- R8: In pattern mode (`mode_sel` = 2), `tx_data` carries word k = {~k, k, ~k, k}, built from 4-bit nibbles, for k = 0, 1, …, 15, and then wraps back to 0. Any word already held is sent first. The sequence restarts at k = 0 each time pattern mode is entered.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` does not change.
- R10: A received word occupies the receive holding register until it is used, and `rx_ready` is 0 during that time. In hold mode (`mode_sel` = 3), no word is used, so after one word arrives `rx_ready` stays 0. No write is made and the held transmit word is kept.
- R11: Boot mode never starts a new transmit word. Echo, pattern and hold modes never raise `cs_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0 boot, 1 echo, 2 pattern, 3 hold |
| rx_valid | input | 1 | Incoming link word present |
| rx_data | input | 16 | Incoming link word |
| rx_ready | output | 1 | Receive holding register empty |
| tx_valid | output | 1 | Outgoing link word present |
| tx_data | output | 16 | Outgoing link word |
| tx_ready | input | 1 | Far end takes the outgoing word |
| cs_we | output | 1 | Control-store write request |
| cs_addr | output | 8 | Control-store write address |
| cs_wdata | output | 48 | Control-store write data |
| cs_busy | input | 1 | Control-store port cannot accept a write this cycle |
| boot_done | output | 1 | All 256 microinstructions written |

## Verification
A word offered on the link is captured at the edge where `rx_ready` is high. It is used at the earliest one edge later. When that word is the third of a group, `cs_we` rises after the edge that uses it. An echoed or pattern word appears on `tx_data` one edge after it is used, and `boot_done` follows the last accepted write by one edge. Inputs are driven just after a rising edge and outputs are sampled at the falling edge. A scoreboard pops one expected write or transmit word for each handshake it sees. Because of that, each result is compared in the cycle it completes, whatever the number of stall cycles added by `cs_busy` or `tx_ready`.

// File: rtl/lcb_pkg.sv
`timescale 1ns/1ps
package lcb_pkg;

    parameter int WORD_W    = 16;
    parameter int LANES     = 3;
    parameter int INSTR_W   = WORD_W * LANES;
    parameter int CS_DEPTH  = 256;
    parameter int CS_AW     = $clog2(CS_DEPTH);
    parameter int PAT_DEPTH = 16;
    parameter int PAT_AW    = $clog2(PAT_DEPTH);
    parameter int LANE_W    = $clog2(LANES);

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [CS_AW-1:0]   cs_addr_t;

    typedef enum logic [1:0] {
        MODE_BOOT    = 2'd0,
        MODE_ECHO    = 2'd1,
        MODE_PATTERN = 2'd2,
        MODE_HOLD    = 2'd3
    } mode_e;

    // One slot of a holding register: a word plus its occupancy flag.
    typedef struct packed {
        logic  valid;
        word_t data;
    } word_slot_t;

    // Pending control-store write.
    typedef struct packed {
        logic     pend;
        cs_addr_t addr;
        instr_t   data;
    } cs_req_t;

    // Test-pattern word for index k: nibbles {~k, k, ~k, k}.
    function automatic word_t pattern_word(input int unsigned idx);
        logic [3:0] k;
        k = idx[3:0];
        return word_t'({~k, k, ~k, k});
    endfunction

endpackage

// File: rtl/lcb_rx_stage.sv
`timescale 1ns/1ps
module lcb_rx_stage
    import lcb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rx_valid,
    input  word_t rx_data,
    input  logic  take,
    output logic  rx_ready,
    output logic  hold_v,
    output word_t hold_word
);

    word_slot_t slot_q;

    // Accept only into an empty slot; the slot is freed when a consumer takes it.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (rx_valid && !slot_q.valid) begin
            slot_q.valid <= 1'b1;
            slot_q.data  <= rx_data;
        end else if (take) begin
            slot_q.valid <= 1'b0;
        end
    end

    assign rx_ready  = !slot_q.valid;
    assign hold_v    = slot_q.valid;
    assign hold_word = slot_q.data;

endmodule

// File: rtl/lcb_packer.sv
`timescale 1ns/1ps
module lcb_packer
    import lcb_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int DEPTH   = CS_DEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     hold_v,
    input  word_t    hold_word,
    input  logic     cs_busy,
    output logic     take,
    output logic     cs_we,
    output cs_addr_t cs_addr,
    output instr_t   cs_wdata,
    output logic     done
);

    localparam int LW = (N_LANES > 1) ? $clog2(N_LANES) : 1;

    logic [LW-1:0] lane_q;
    word_t         parts_q [N_LANES-1];
    cs_req_t       req_q;
    cs_addr_t      addr_q;
    logic          done_q;
    logic          last_lane;
    logic          wr_accept;
    instr_t        full_instr;

    assign last_lane = (lane_q == LW'(N_LANES - 1));
    assign wr_accept = req_q.pend && !cs_busy;

    // A completing word waits while a previous write is still pending.
    assign take = en && hold_v && (done_q || !last_lane || !req_q.pend);

    // Assemble lanes, first word in the least significant position.
    always_comb begin
        full_instr = '0;
        for (int i = 0; i < N_LANES - 1; i++) begin
            full_instr[i*WORD_W +: WORD_W] = parts_q[i];
        end
        full_instr[(N_LANES-1)*WORD_W +: WORD_W] = hold_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
            req_q  <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
            for (int i = 0; i < N_LANES - 1; i++) parts_q[i] <= '0;
        end else begin
            if (wr_accept) begin
                req_q.pend <= 1'b0;
                addr_q     <= addr_q + 1'b1;
                if (addr_q == cs_addr_t'(DEPTH - 1)) done_q <= 1'b1;
            end
            if (take && !done_q) begin
                if (last_lane) begin
                    req_q.pend <= 1'b1;
                    req_q.addr <= addr_q;
                    req_q.data <= full_instr;
                    lane_q     <= '0;
                end else begin
                    parts_q[lane_q] <= hold_word;
                    lane_q          <= lane_q + 1'b1;
                end
            end
        end
    end

    assign cs_we    = req_q.pend;
    assign cs_addr  = req_q.addr;
    assign cs_wdata = req_q.data;
    assign done     = done_q;

endmodule

// File: rtl/lcb_tx_stage.sv
`timescale 1ns/1ps
module lcb_tx_stage
    import lcb_pkg::*;
#(
    parameter int ROM_DEPTH = PAT_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  hold_v,
    input  word_t hold_word,
    input  logic  tx_ready,
    output logic  take,
    output logic  tx_valid,
    output word_t tx_data
);

    localparam int RW = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

    word_t      rom [ROM_DEPTH];
    word_slot_t out_q;
    logic [RW-1:0] ptr_q;
    logic       slot_free;
    logic       pat_load;

    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
        assign rom[g] = pattern_word(g);
    end

    assign slot_free = !out_q.valid || tx_ready;
    assign take      = (mode == MODE_ECHO) && hold_v && slot_free;
    assign pat_load  = (mode == MODE_PATTERN) && slot_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            ptr_q <= '0;
        end else begin
            if (take) begin
                out_q.valid <= 1'b1;
                out_q.data  <= hold_word;
            end else if (pat_load) begin
                out_q.valid <= 1'b1;
                out_q.data  <= rom[ptr_q];
            end else if (out_q.valid && tx_ready) begin
                out_q.valid <= 1'b0;
            end

            if (mode != MODE_PATTERN) begin
                ptr_q <= '0;
            end else if (pat_load) begin
                ptr_q <= (ptr_q == RW'(ROM_DEPTH - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    assign tx_valid = out_q.valid;
    assign tx_data  = out_q.data;

endmodule

// File: rtl/link_cs_loader.sv
`timescale 1ns/1ps
module link_cs_loader
    import lcb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_sel,
    input  logic                rx_valid,
    input  logic [WORD_W-1:0]   rx_data,
    output logic                rx_ready,
    output logic                tx_valid,
    output logic [WORD_W-1:0]   tx_data,
    input  logic                tx_ready,
    output logic                cs_we,
    output logic [CS_AW-1:0]    cs_addr,
    output logic [INSTR_W-1:0]  cs_wdata,
    input  logic                cs_busy,
    output logic                boot_done
);

    mode_e mode;
    logic  hold_v;
    word_t hold_word;
    logic  pack_take;
    logic  tx_take;

    assign mode = mode_e'(mode_sel);

    lcb_rx_stage u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .take      (pack_take | tx_take),
        .rx_ready  (rx_ready),
        .hold_v    (hold_v),
        .hold_word (hold_word)
    );

    lcb_packer #(
        .N_LANES (LANES),
        .DEPTH   (CS_DEPTH)
    ) u_pack (
        .clk       (clk),
        .rst       (rst),
        .en        (mode == MODE_BOOT),
        .hold_v    (hold_v),
        .hold_word (hold_word),
        .cs_busy   (cs_busy),
        .take      (pack_take),
        .cs_we     (cs_we),
        .cs_addr   (cs_addr),
        .cs_wdata  (cs_wdata),
        .done      (boot_done)
    );

    lcb_tx_stage #(
        .ROM_DEPTH (PAT_DEPTH)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .hold_v    (hold_v),
        .hold_word (hold_word),
        .tx_ready  (tx_ready),
        .take      (tx_take),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

endmodule

// File: rtl/lcb_checker.sv
`timescale 1ns/1ps
module lcb_checker
    import lcb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [1:0]          mode_sel,
    input logic                rx_valid,
    input logic [WORD_W-1:0]   rx_data,
    input logic                rx_ready,
    input logic                tx_valid,
    input logic [WORD_W-1:0]   tx_data,
    input logic                tx_ready,
    input logic                cs_we,
    input logic [CS_AW-1:0]    cs_addr,
    input logic [INSTR_W-1:0]  cs_wdata,
    input logic                cs_busy,
    input logic                boot_done
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!cs_we && !tx_valid && !boot_done && rx_ready));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (cs_we && !cs_busy) |=> (!cs_we || cs_addr == CS_AW'($past(cs_addr) + 1'b1)));

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (cs_we && cs_busy) |=> (cs_we && $stable(cs_addr) && $stable(cs_wdata)));

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> boot_done);

    p_no_write_after_done_r5: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> !cs_we);

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_rx_held_in_hold_mode_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready && mode_sel == 2'd3) |=> !rx_ready);

    p_boot_no_tx_r11: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid && mode_sel == 2'd0) |=> !tx_valid);

    p_test_modes_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        (!cs_we && mode_sel != 2'd0) |=> !cs_we);

endmodule

bind link_cs_loader lcb_checker u_chk (.*);

// File: tb/sim_link_cs_loader.sv
`timescale 1ns/1ps
module sim_link_cs_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'd0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic        tx_ready = 1'b0;
    logic        cs_we;
    logic [7:0]  cs_addr;
    logic [47:0] cs_wdata;
    logic        cs_busy = 1'b0;
    logic        boot_done;

    int n_cmp  = 0;
    int n_bad  = 0;
    int wr_count = 0;
    bit busy_en = 0;
    bit txr_en  = 0;
    bit done_chk = 0;
    bit prev_stall = 0;
    logic [7:0]  prev_addr;
    logic [47:0] prev_data;
    bit prev_txhold = 0;
    logic [15:0] prev_tx;
    logic [15:0] lfsr = 16'hACE1;

    logic [55:0] cs_q [$];
    logic [15:0] tx_q [$];

    always #2 clk = ~clk;

    link_cs_loader u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .cs_we(cs_we), .cs_addr(cs_addr), .cs_wdata(cs_wdata),
        .cs_busy(cs_busy), .boot_done(boot_done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] pat(input int k);
        logic [3:0] n;
        n = 4'(k);
        return {~n, n, ~n, n};
    endfunction

    function automatic logic [15:0] boot_word(input int i, input int l);
        if (i == 0) return 16'h0000;
        if (i == 1) return 16'hFFFF;
        return {8'(i) ^ 8'h3C, 4'(l), 4'hC};
    endfunction

    task automatic send_word(input logic [15:0] w);
        rx_data  = w;
        rx_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (rx_ready) break;
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_empty();
        while (cs_q.size() != 0 || tx_q.size() != 0) @(posedge clk);
        cycles(3);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Random stall sources
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (busy_en) cs_busy  = lfsr[0] & lfsr[3];
        if (txr_en)  tx_ready = lfsr[1] | lfsr[5];
    end

    // Monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (done_chk) begin
                done_chk = 0;
                check(boot_done == 1'b1, "R5 done after last write", boot_done, 1);
                check(cs_we == 1'b0, "R5 no write after done", cs_we, 0);
            end
            if (prev_stall) begin
                check(cs_we && cs_addr == prev_addr && cs_wdata == prev_data,
                      "R4 write held while busy", {cs_we, cs_addr, cs_wdata}, {1'b1, prev_addr, prev_data});
            end
            if (prev_txhold) begin
                check(tx_valid && tx_data == prev_tx, "R9 tx held while not ready",
                      {tx_valid, tx_data}, {1'b1, prev_tx});
            end
            prev_stall = cs_we && cs_busy;
            prev_addr  = cs_addr;
            prev_data  = cs_wdata;
            prev_txhold = tx_valid && !tx_ready;
            prev_tx     = tx_data;
            if (cs_we && !cs_busy) begin
                if (cs_q.size() == 0) begin
                    check(0, "R5/R11 unexpected write", {cs_addr, cs_wdata}, 0);
                end else begin
                    logic [55:0] e;
                    e = cs_q.pop_front();
                    check(cs_addr == e[55:48], "R3 write address", cs_addr, e[55:48]);
                    check(cs_wdata == e[47:0], "R2/R6 write data", cs_wdata, e[47:0]);
                    wr_count++;
                    if (wr_count == 256) begin
                        check(boot_done == 1'b0, "R5 done not early", boot_done, 0);
                        done_chk = 1;
                    end
                end
            end
            if (tx_valid && tx_ready) begin
                if (tx_q.size() == 0) begin
                    check(0, "R11 unexpected tx word", tx_data, 0);
                end else begin
                    logic [15:0] t;
                    t = tx_q.pop_front();
                    check(tx_data == t, "R7/R8 tx word", tx_data, t);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired, run hung");
        finish_run();
    end

    // Stimulus
    initial begin
        cycles(3);
        check(rx_ready == 1 && tx_valid == 0 && cs_we == 0 && boot_done == 0,
              "R1 reset state", {rx_ready, tx_valid, cs_we, boot_done}, 4'b1000);
        rst = 1'b0;
        cycles(1);
        check(rx_ready == 1 && tx_valid == 0 && cs_we == 0 && boot_done == 0,
              "R1 state after reset", {rx_ready, tx_valid, cs_we, boot_done}, 4'b1000);

        // R2 R3 R4 R6: full boot image with random busy
        busy_en = 1;
        for (int i = 0; i < 256; i++) begin
            cs_q.push_back({8'(i), boot_word(i, 2), boot_word(i, 1), boot_word(i, 0)});
            for (int l = 0; l < 3; l++) send_word(boot_word(i, l));
        end
        wait_empty();
        busy_en = 0;
        cs_busy = 1'b0;
        cycles(2);
        check(wr_count == 256, "R3 all writes seen", wr_count, 256);
        check(boot_done == 1'b1, "R5 done stays high", boot_done, 1);

        // R5: words after done are accepted and dropped
        for (int i = 0; i < 6; i++) send_word(16'h1234 + 16'(i));
        cycles(5);
        check(rx_ready == 1'b1, "R5 post-done words discarded", rx_ready, 1);
        check(wr_count == 256 && cs_we == 0, "R5 no extra write", wr_count, 256);
        check(tx_valid == 1'b0, "R11 boot mode no tx", tx_valid, 0);

        // R7: echo with random backpressure
        mode_sel = 2'd1;
        txr_en = 1;
        for (int i = 0; i < 12; i++) begin
            logic [15:0] w;
            w = 16'h5A00 ^ 16'(i * 16'h0111);
            tx_q.push_back(w);
            send_word(w);
        end
        wait_empty();
        txr_en = 0;
        tx_ready = 1'b0;
        cycles(2);
        check(tx_valid == 1'b0 && cs_we == 0, "R7/R11 echo drained, no write", {tx_valid, cs_we}, 0);

        // R8: pattern sequence, wrap past 15
        mode_sel = 2'd2;
        cycles(2);
        for (int n = 0; n < 20; n++) begin
            tx_q.push_back(pat(n % 16));
            tx_ready = 1'b1;
            cycles(1);
            tx_ready = 1'b0;
            cycles(1);
        end
        check(tx_q.size() == 0, "R8 all pattern words seen", tx_q.size(), 0);

        // R10: hold mode keeps words
        mode_sel = 2'd3;
        cycles(1);
        send_word(16'hBEEF);
        cycles(5);
        check(rx_ready == 1'b0, "R10 word held in hold mode", rx_ready, 0);
        check(tx_valid == 1'b1 && tx_data == pat(4), "R10 tx word kept", tx_data, pat(4));
        check(cs_we == 1'b0, "R11 hold mode no write", cs_we, 0);

        // Held word delivered once echo resumes
        tx_q.push_back(pat(4));
        tx_q.push_back(16'hBEEF);
        mode_sel = 2'd1;
        tx_ready = 1'b1;
        wait_empty();
        check(rx_ready == 1'b1, "R10 held word consumed by echo", rx_ready, 1);
        tx_ready = 1'b0;

        // R8: re-entry restarts at k=0
        mode_sel = 2'd2;
        cycles(2);
        for (int n = 0; n < 3; n++) begin
            tx_q.push_back(pat(n));
            tx_ready = 1'b1;
            cycles(1);
            tx_ready = 1'b0;
            cycles(1);
        end
        check(tx_q.size() == 0, "R8 restart sequence seen", tx_q.size(), 0);
        mode_sel = 2'd3;
        cycles(4);
        finish_run();
    end

endmodule